// File: doc/BRIEF.md
# Two-Way Set-Associative Write-Back Cache

This block sits between a processor port and a main-memory port. The processor issues byte-wide reads and writes on a 24-bit byte address and holds its request until it sees a one-cycle completion strobe. Main memory is reached one 4-byte block per transaction.

Each set has two slots. Every slot keeps a tag, a valid flag, a dirty flag and a use flag. A hit is served from the cache in the cycle it is requested. On a miss the block picks a victim slot. If that victim is dirty, it writes the victim back. It then fetches the missing block, and in the following cycle it completes the original access from the cache. Writes never go straight to memory; they only mark the line dirty.

The number of sets is a parameter. The default uses a small index so that simulation stays small, and a 13-bit index gives the full-size arrangement. Two counters report hits and misses so that a test can compare hit ratios against a reference for known access patterns.

Top module: `wb2way_cache`

## Requirements
- R1: The byte address is split into a byte offset in bits [1:0], a set index in the next SET_W bits, and a tag in all remaining upper bits. A read returns byte `offset` of the 32-bit block, where byte 0 is bits [7:0].
- R2: The tags of both slots in the indexed set are compared in parallel. On a hit, `cpu_done` is asserted in the same cycle as the request, and no memory transaction takes place.
- R3: A write that hits replaces only the addressed byte in the cache line and marks the line dirty. No memory write occurs at that time.
- R4: On a miss, an invalid slot is chosen before a valid one. When both slots are invalid, slot 0 is chosen. Filling an invalid slot causes no write-back.
- R5: Every completed access sets the use flag of the slot it touched and clears the use flag of the other slot in the set. When both slots are valid, the miss victim is the slot whose use flag is 0.
- R6: A dirty victim is written to memory as one full block at block address {victim tag, set} before the refill read is issued. A clean victim is overwritten with no memory write.
- R7: A refill reads block address {request tag, set} and installs the block as valid and clean. The access then completes from the cache; for a write miss, the byte is applied and the line becomes dirty.
- R8: Each memory transaction is held with stable `mem_we`, `mem_addr` and `mem_wdata` until `mem_ready` is seen at a clock edge. Exactly one block moves per transaction.
- R9: `hit_count` rises by one for each access that completes without a miss. `miss_count` rises by one for each miss. The completion that follows a refill is not counted as a hit.
- R10: After reset, every slot is invalid, clean and unused, both counters are zero, and no memory request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Access request, held until `cpu_done` |
| cpu_we | input | 1 | 1 = byte write, 0 = byte read |
| cpu_addr | input | ADDR_W | Byte address |
| cpu_wdata | input | 8 | Write byte |
| cpu_done | output | 1 | Access completes this cycle |
| cpu_rdata | output | 8 | Read byte, valid with `cpu_done` |
| mem_req | output | 1 | Memory transaction pending |
| mem_we | output | 1 | 1 = block write-back, 0 = block fetch |
| mem_addr | output | ADDR_W-2 | Block address |
| mem_wdata | output | 32 | Write-back block |
| mem_ready | input | 1 | Memory accepts/delivers this cycle |
| mem_rdata | input | 32 | Fetched block, valid with `mem_ready` |
| hit_count | output | CNT_W | Hits since reset |
| miss_count | output | CNT_W | Misses since reset |

## Verification
Two events can fall in adjacent cycles: the end of a dirty write-back and the issue of the refill read. The ordering between them is the one most likely to break. To provoke it, the test fills a set with two dirty lines, touches one of them so the other becomes the victim, and then misses into that set while the memory model answers with zero to two wait cycles. The check requires the written-back block to carry the exact bytes written earlier, at the old tag's block address, ahead of the fetch. A randomized mix over four sets and four tags then keeps these paths interleaved with hits, and the hit and miss counts are compared after every access.

// File: rtl/wb2way_cache.sv
module wb2way_cache #(
  parameter int ADDR_W = 24,
  parameter int SET_W  = 5,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [7:0]        cpu_wdata,
  output logic              cpu_done,
  output logic [7:0]        cpu_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-3:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ready,
  input  logic [31:0]       mem_rdata,
  output logic [CNT_W-1:0]  hit_count,
  output logic [CNT_W-1:0]  miss_count
);
  localparam int TAG_W = ADDR_W - SET_W - 2;
  localparam int SETS  = 1 << SET_W;

  typedef enum logic [1:0] {S_LOOK, S_EVICT, S_FILL, S_FINISH} st_t;
  st_t st;

  logic [TAG_W-1:0]         tag_q [2][SETS];
  logic [31:0]              dat_q [2][SETS];
  logic [1:0][SETS-1:0]     vld_q, drt_q, use_q;
  logic                     vic_q;

  logic [1:0]        off;
  logic [SET_W-1:0]  set;
  logic [TAG_W-1:0]  tag;
  logic [1:0]        way_hit;
  logic              hit, hw, serve, start_miss, vic_new;
  logic [31:0]       line;

  assign off = cpu_addr[1:0];
  assign set = cpu_addr[SET_W+1:2];
  assign tag = cpu_addr[ADDR_W-1:SET_W+2];

  assign way_hit[0] = vld_q[0][set] && (tag_q[0][set] == tag);
  assign way_hit[1] = vld_q[1][set] && (tag_q[1][set] == tag);
  assign hit        = |way_hit;
  assign hw         = way_hit[1];

  assign serve      = cpu_req && hit && (st == S_LOOK || st == S_FINISH);
  assign start_miss = cpu_req && !hit && (st == S_LOOK);
  assign vic_new    = !vld_q[0][set] ? 1'b0 :
                      !vld_q[1][set] ? 1'b1 : use_q[0][set];

  assign line      = dat_q[hw][set];
  assign cpu_done  = serve;
  assign cpu_rdata = line[{off, 3'b000} +: 8];

  assign mem_req   = (st == S_EVICT) || (st == S_FILL);
  assign mem_we    = (st == S_EVICT);
  assign mem_addr  = (st == S_EVICT) ? {tag_q[vic_q][set], set} : {tag, set};
  assign mem_wdata = dat_q[vic_q][set];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_LOOK;
      vic_q      <= 1'b0;
      vld_q      <= '0;
      drt_q      <= '0;
      use_q      <= '0;
      hit_count  <= '0;
      miss_count <= '0;
    end else begin
      case (st)
        S_LOOK: begin
          if (serve) begin
            hit_count <= hit_count + 1'b1;
          end else if (start_miss) begin
            miss_count <= miss_count + 1'b1;
            vic_q      <= vic_new;
            st <= (vld_q[vic_new][set] && drt_q[vic_new][set]) ? S_EVICT : S_FILL;
          end
        end
        S_EVICT: if (mem_ready) begin
          drt_q[vic_q][set] <= 1'b0;
          st                <= S_FILL;
        end
        S_FILL: if (mem_ready) begin
          vld_q[vic_q][set] <= 1'b1;
          drt_q[vic_q][set] <= 1'b0;
          st                <= S_FINISH;
        end
        default: st <= S_LOOK;
      endcase
      if (serve) begin
        use_q[hw][set]  <= 1'b1;
        use_q[~hw][set] <= 1'b0;
        if (cpu_we) drt_q[hw][set] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (st == S_FILL && mem_ready) begin
      tag_q[vic_q][set] <= tag;
      dat_q[vic_q][set] <= mem_rdata;
    end
    if (serve && cpu_we) dat_q[hw][set][{off, 3'b000} +: 8] <= cpu_wdata;
  end
endmodule

// File: rtl/wb2way_cache_chk.sv
module wb2way_cache_chk #(
  parameter int ADDR_W = 24,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_req,
  input logic              cpu_done,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-3:0] mem_addr,
  input logic [31:0]       mem_wdata,
  input logic              mem_ready,
  input logic [CNT_W-1:0]  hit_count,
  input logic [CNT_W-1:0]  miss_count
);
  // R8
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata));

  // R6
  evict_then_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we && mem_ready |=> mem_req && !mem_we);

  // R7
  fill_then_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_we && mem_ready |=> cpu_done);

  // R2
  hit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |-> !mem_req);

  // R9
  hit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_count != $past(hit_count)) |-> (hit_count == $past(hit_count) + CNT_W'(1)) && $past(cpu_done));

  // R9
  miss_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_count != $past(miss_count)) |->
      (miss_count == $past(miss_count) + CNT_W'(1)) && $past(cpu_req) && !$past(cpu_done) && !$past(mem_req));
endmodule

bind wb2way_cache wb2way_cache_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) chk_i (.*);

// File: tb/wb2way_cache_tb_top.sv
`timescale 1ns/1ps
module wb2way_cache_tb_top;
  localparam int AW = 24;
  localparam int SW = 5;
  localparam int TW = AW - SW - 2;
  localparam int NS = 1 << SW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cpu_req = 1'b0, cpu_we = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic [7:0] cpu_wdata = '0;
  logic cpu_done;
  logic [7:0] cpu_rdata;
  logic mem_req, mem_we;
  logic [AW-3:0] mem_addr;
  logic [31:0] mem_wdata;
  logic mem_ready = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic [15:0] hit_count, miss_count;

  wb2way_cache #(.ADDR_W(AW), .SET_W(SW), .CNT_W(16)) dut_i (.*);

  always #10 clk = ~clk;

  int nchk = 0, nfail = 0;
  logic [31:0] mem_m [int];
  int wb_cnt = 0, rd_cnt = 0;
  logic [AW-3:0] last_wb_addr;
  logic [31:0] last_wb_data;

  logic [TW-1:0] m_tag [2][NS];
  logic [31:0]   m_dat [2][NS];
  logic          m_vld [2][NS];
  logic          m_drt [2][NS];
  logic          m_use [2][NS];
  int exp_hits = 0, exp_miss = 0;

  function automatic logic [31:0] mem_read(int k);
    if (mem_m.exists(k)) return mem_m[k];
    return (k * 32'h9E3779B1) ^ 32'h5A17C3E9;
  endfunction

  function automatic logic [AW-1:0] mkaddr(int tg, int s, int o);
    return {TW'(tg), SW'(s), 2'(o)};
  endfunction

  task automatic check(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // memory model with 0..2 wait cycles
  initial begin
    int waited = 0, lat = 0;
    forever begin
      @(negedge clk);
      if (mem_ready) begin
        mem_ready = 1'b0;
        waited = 0;
        lat = $urandom_range(0, 2);
      end else if (rst_n && mem_req) begin
        if (waited >= lat) begin
          mem_ready = 1'b1;
          if (mem_we) begin
            mem_m[int'(mem_addr)] = mem_wdata;
            wb_cnt++;
            last_wb_addr = mem_addr;
            last_wb_data = mem_wdata;
          end else begin
            mem_rdata = mem_read(int'(mem_addr));
            rd_cnt++;
          end
        end else waited++;
      end
    end
  end

  task automatic do_access(input bit we, input int tg, input int s, input int o,
                           input logic [7:0] wd, input string rq);
    int hw = -1, v = 0, cyc = 0, wb0, rd0;
    bit exp_hit, exp_wb = 0;
    logic [AW-3:0] ewb_a;
    logic [31:0] ewb_d;
    logic [7:0] exp_rd, got;
    for (int w = 0; w < 2; w++)
      if (m_vld[w][s] && m_tag[w][s] == TW'(tg)) hw = w;
    exp_hit = (hw >= 0);
    if (!exp_hit) begin
      v = !m_vld[0][s] ? 0 : !m_vld[1][s] ? 1 : (m_use[0][s] ? 1 : 0);
      if (m_vld[v][s] && m_drt[v][s]) begin
        exp_wb = 1;
        ewb_a = {m_tag[v][s], SW'(s)};
        ewb_d = m_dat[v][s];
      end
      m_dat[v][s] = mem_read(int'({TW'(tg), SW'(s)}));
      m_tag[v][s] = TW'(tg);
      m_vld[v][s] = 1'b1;
      m_drt[v][s] = 1'b0;
      hw = v;
      exp_miss++;
    end else exp_hits++;
    exp_rd = m_dat[hw][s][o*8 +: 8];
    if (we) begin
      m_dat[hw][s][o*8 +: 8] = wd;
      m_drt[hw][s] = 1'b1;
    end
    m_use[hw][s] = 1'b1;
    m_use[1-hw][s] = 1'b0;

    wb0 = wb_cnt; rd0 = rd_cnt;
    cpu_req = 1'b1; cpu_we = we; cpu_addr = mkaddr(tg, s, o); cpu_wdata = wd;
    #1;
    while (!cpu_done && cyc < 200) begin
      @(negedge clk); #1; cyc++;
    end
    got = cpu_rdata;
    check(cyc < 200, rq, "access timeout", cyc, 0);
    @(posedge clk); @(negedge clk);
    cpu_req = 1'b0;
    if (!we) check(got == exp_rd, rq, "read byte", got, exp_rd);
    check(hit_count == 16'(exp_hits), rq, "hit count", hit_count, exp_hits);
    check(miss_count == 16'(exp_miss), rq, "miss count", miss_count, exp_miss);
    check((cyc == 0) == exp_hit, rq, "hit latency", cyc, 0);
    check(rd_cnt - rd0 == (exp_hit ? 0 : 1), rq, "fetch count", rd_cnt - rd0, exp_hit ? 0 : 1);
    check(wb_cnt - wb0 == int'(exp_wb), rq, "write-back count", wb_cnt - wb0, exp_wb);
    if (exp_wb) begin
      check(last_wb_addr == ewb_a, rq, "write-back address", last_wb_addr, ewb_a);
      check(last_wb_data == ewb_d, rq, "write-back data", last_wb_data, ewb_d);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    for (int w = 0; w < 2; w++)
      for (int s = 0; s < NS; s++) begin
        m_vld[w][s] = 0; m_drt[w][s] = 0; m_use[w][s] = 0; m_tag[w][s] = '0; m_dat[w][s] = '0;
      end
    repeat (3) @(negedge clk);
    // R10 reset state
    check(hit_count == 0 && miss_count == 0, "R10", "counters in reset", {hit_count, miss_count}, 0);
    check(!mem_req, "R10", "mem_req in reset", mem_req, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!mem_req && !cpu_done, "R10", "idle after reset", {mem_req, cpu_done}, 0);

    do_access(0, 1, 0, 0, 8'h00, "R4");          // empty set -> slot 0
    for (int o = 0; o < 4; o++) do_access(0, 1, 0, o, 8'h00, "R1");
    do_access(0, 2, 0, 3, 8'h00, "R4");          // other slot still invalid
    do_access(1, 1, 0, 2, 8'hA5, "R3");          // write hit, no memory write
    do_access(0, 1, 0, 2, 8'h00, "R3");
    do_access(0, 2, 0, 1, 8'h00, "R2");          // hit, tag 1 slot becomes victim
    do_access(0, 3, 0, 0, 8'h00, "R6");          // dirty victim written back
    do_access(0, 4, 0, 1, 8'h00, "R5");          // clean victim, by use flag
    do_access(1, 5, 1, 3, 8'h3C, "R7");          // write miss
    do_access(0, 5, 1, 3, 8'h00, "R7");
    do_access(1, 6, 1, 0, 8'hC3, "R7");
    do_access(0, 5, 1, 0, 8'h00, "R5");
    do_access(0, 7, 1, 0, 8'h00, "R6");          // evicts dirty tag 6 line
    do_access(0, 1, 0, 2, 8'h00, "R6");          // refetched block holds written byte

    for (int i = 0; i < 500; i++) begin
      bit we = ($urandom_range(0, 9) < 4);
      do_access(we, $urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 3),
                8'($urandom), we ? "R9" : "R8");
    end

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule